// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 24-clock serial analog-to-digital converter that sends a 14-bit result. It drives an active-low chip select and a serial clock that idles low (clock polarity 0, phase 0). The serial clock comes from the system clock through a programmable divider. The controller captures the converter's data line on every rising serial-clock edge. From the 24 received bits it builds a 14-bit code and two trailing sub-bits. It presents them with a one-cycle valid strobe and holds them until the next strobe. Any one in the eight leading bits, which the converter always sends as zeros, raises a framing-error flag.

A start pulse begins a conversion. In continuous mode the controller issues conversions back to back, as fast as the minimum chip-select high time allows. An abort input raises chip select at once and cancels the conversion. A channel-select output for an external analog multiplexer moves to the next channel right after the sixth falling clock edge, which ends the converter's acquisition. The buffer ahead of the converter then has the rest of the frame to settle. Guard counters, counted in system clock cycles, enforce the setup time from chip-select fall to the first clock edge and the minimum chip-select high time.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and just after it is released, cs_n=1, sclk=0, busy=0, valid=0, frame_err=0, code=0 and mux_sel=0.
- R2: sclk is 0 whenever cs_n is 1. Inside a frame, every high phase of sclk lasts exactly half_div system cycles.
- R3: A completed frame has exactly 24 rising and 24 falling sclk edges. cs_n rises in the cycle after the 24th falling edge has been registered.
- R4: Bit k (k=1..24) is sampled on the k-th rising sclk edge. code takes bits 9..22 (bit 9 is the MSB), and sub_bits takes bits 23 and 24 (bit 23 is sub_bits[1]). valid is a one-cycle pulse in the same cycle that cs_n rises. code, sub_bits and frame_err hold until the next valid.
- R5: frame_err is updated with valid. It is 1 if any of bits 1..8 was 1, and 0 otherwise.
- R6: The first rising sclk edge comes exactly SETUP_CYC+half_div system cycles after cs_n falls.
- R7: Between two frames, cs_n stays high for at least CSH_CYC system cycles. A start while this guard is still running is ignored.
- R8: A start while busy=1 has no effect: no extra frame and no extra valid.
- R9: While cont_en=1, a new frame starts by itself, with cs_n high for exactly CSH_CYC cycles between frames.
- R10: abort during a frame drives cs_n to 1 and sclk to 0 on the next clock edge. No valid follows, and code is unchanged.
- R11: One cycle after the 6th falling sclk edge of a frame is registered, mux_sel advances by one, wrapping from chan_last to 0. A frame aborted before that edge leaves mux_sel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin one conversion |
| abort | input | 1 | Cancel the frame in progress |
| cont_en | input | 1 | Back-to-back conversion mode |
| half_div | input | DIV_W | System cycles per serial-clock half period |
| chan_last | input | CH_W | Highest external channel index |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| miso | input | 1 | Serial data from the converter |
| busy | output | 1 | A frame is in progress |
| valid | output | 1 | Result strobe |
| code | output | 14 | Conversion code, MSB first as received |
| sub_bits | output | 2 | Two trailing sub-bits |
| frame_err | output | 1 | Leading zeros were violated |
| mux_sel | output | CH_W | External channel select |

## Verification
A wrong frame-edge count shows at the very next valid: the rising-edge total differs from 24, or the bits in the code are shifted by one or more positions. A divider or setup counter that is off by one shows as a wrong high-phase length or a wrong first-edge delay in the frame where it happens. An error in the chip-select guard shows as a wrong gap length when the next frame starts. A channel counter that advances at the wrong edge, or fails to wrap, shows at the first channel change, where the bench compares the falling-edge count and the new index.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_LEN = 24;
  localparam int LEAD_LEN  = 8;
  localparam int CODE_W    = 14;
  localparam int SUBB_W    = 2;
  localparam int ACQ_FALLS = 6;
  localparam int EDGE_W    = $clog2(FRAME_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLOCK = 2'd2
  } frame_st_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] phase_q, phase_d, half_m1;
  logic             sclk_q, sclk_d, rise_q, rise_d, fall_q, fall_d, tick;

  always_comb begin
    half_m1 = (half_div == '0) ? '0 : half_div - DIV_W'(1);
    tick    = run && (phase_q == half_m1);
    phase_d = (!run || tick) ? '0 : phase_q + DIV_W'(1);
    sclk_d  = run && (tick ? !sclk_q : sclk_q);
    rise_d  = tick && !sclk_q;
    fall_d  = tick && sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sclk_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sclk_q  <= sclk_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign sclk   = sclk_q;
  assign rise_p = rise_q;
  assign fall_p = fall_q;

  AST_EDGE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q) else $error("sclk rose without run"); // R2
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift
  import adc_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sample,
  input  logic                 miso,
  output logic [FRAME_LEN-1:0] word
);
  logic [FRAME_LEN-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clear)       sh_d = '0;
    else if (sample) sh_d = {sh_q[FRAME_LEN-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CH_W      = 2,
  parameter int SETUP_CYC = 10,
  parameter int CSH_CYC   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            cont_en,
  input  logic [CH_W-1:0] chan_last,
  input  logic            sclk_i,
  input  logic            fall_i,
  output logic            cs_n,
  output logic            busy,
  output logic            run,
  output logic            clear,
  output logic            done,
  output logic [CH_W-1:0] mux_sel
);
  localparam int SU_W  = $clog2(SETUP_CYC + 1);
  localparam int CSH_W = $clog2(CSH_CYC + 1);
  localparam int CK_W  = $clog2(SETUP_CYC + CSH_CYC + FRAME_LEN + 2);

  frame_st_e         st_q, st_d;
  logic [SU_W-1:0]   su_q, su_d;
  logic [CSH_W-1:0]  csh_q, csh_d;
  logic [EDGE_W-1:0] fcnt_q, fcnt_d;
  logic [CH_W-1:0]   mux_q, mux_d;
  logic              cs_q, cs_d;
  logic              csh_ok, accept, last_fall, acq_fall;

  always_comb begin
    csh_ok    = (csh_q >= CSH_W'(CSH_CYC - 1));
    accept    = (st_q == ST_IDLE) && (start || cont_en) && csh_ok;
    last_fall = (st_q == ST_CLOCK) && fall_i && (fcnt_q == EDGE_W'(FRAME_LEN - 1));
    acq_fall  = (st_q == ST_CLOCK) && fall_i && (fcnt_q == EDGE_W'(ACQ_FALLS - 1));

    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SETUP;
      ST_SETUP: if (abort) st_d = ST_IDLE;
                else if (su_q == SU_W'(SETUP_CYC - 1)) st_d = ST_CLOCK;
      ST_CLOCK: if (abort || last_fall) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase

    su_d   = (st_q == ST_SETUP) ? su_q + SU_W'(1) : '0;
    csh_d  = (st_q != ST_IDLE) ? '0 : (csh_ok ? csh_q : csh_q + CSH_W'(1));
    fcnt_d = (st_q != ST_CLOCK) ? '0 : (fall_i ? fcnt_q + EDGE_W'(1) : fcnt_q);
    mux_d  = mux_q;
    if (acq_fall && !abort) mux_d = (mux_q >= chan_last) ? '0 : mux_q + CH_W'(1);
    cs_d   = (st_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      su_q   <= '0;
      csh_q  <= '0;
      fcnt_q <= '0;
      mux_q  <= '0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      su_q   <= su_d;
      csh_q  <= csh_d;
      fcnt_q <= fcnt_d;
      mux_q  <= mux_d;
      cs_q   <= cs_d;
    end
  end

  assign cs_n    = cs_q;
  assign busy    = (st_q != ST_IDLE);
  assign run     = (st_q == ST_CLOCK) && !abort && !last_fall;
  assign clear   = accept;
  assign done    = last_fall && !abort;
  assign mux_sel = mux_q;

  // checker counters observing the pins
  logic [CK_W-1:0] hi_len, lo_len, nfall;
  logic            sclk_d1, abort_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len   <= '0;
      lo_len   <= '0;
      nfall    <= '0;
      sclk_d1  <= 1'b0;
      abort_d1 <= 1'b0;
    end else begin
      sclk_d1  <= sclk_i;
      abort_d1 <= abort;
      if (cs_q) hi_len <= (hi_len == '1) ? hi_len : hi_len + CK_W'(1);
      else      hi_len <= '0;
      if (!cs_q) lo_len <= (lo_len == '1) ? lo_len : lo_len + CK_W'(1);
      else       lo_len <= '0;
      if (cs_q && !cs_d)            nfall <= '0;
      else if (sclk_d1 && !sclk_i)  nfall <= nfall + CK_W'(1);
    end
  end

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_i) else $error("sclk high while deselected"); // R2
  AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_len >= CK_W'(CSH_CYC))) else $error("cs high too short"); // R7
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_i) |-> (lo_len >= CK_W'(SETUP_CYC))) else $error("setup too short"); // R6
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_q) && !abort_d1) |-> (nfall == CK_W'(FRAME_LEN))) else $error("frame edges"); // R3
  AST_MUX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_q) |-> !cs_q) else $error("mux moved outside frame"); // R11
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int CH_W      = 2,
  parameter int SETUP_CYC = 10,
  parameter int CSH_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cont_en,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CH_W-1:0]   chan_last,
  output logic              cs_n,
  output logic              sclk,
  input  logic              miso,
  output logic              busy,
  output logic              valid,
  output logic [CODE_W-1:0] code,
  output logic [SUBB_W-1:0] sub_bits,
  output logic              frame_err,
  output logic [CH_W-1:0]   mux_sel
);
  logic                 run, clear, done, rise_p, fall_p;
  logic [FRAME_LEN-1:0] word;

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
    .sclk(sclk), .rise_p(rise_p), .fall_p(fall_p)
  );

  adc_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample(rise_p),
    .miso(miso), .word(word)
  );

  adc_frame_ctrl #(.CH_W(CH_W), .SETUP_CYC(SETUP_CYC), .CSH_CYC(CSH_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cont_en(cont_en),
    .chan_last(chan_last), .sclk_i(sclk), .fall_i(fall_p), .cs_n(cs_n),
    .busy(busy), .run(run), .clear(clear), .done(done), .mux_sel(mux_sel)
  );

  logic [CODE_W-1:0] code_q, code_d;
  logic [SUBB_W-1:0] sub_q, sub_d;
  logic              ferr_q, ferr_d, val_q;

  always_comb begin
    code_d = code_q;
    sub_d  = sub_q;
    ferr_d = ferr_q;
    if (done) begin
      code_d = word[CODE_W+SUBB_W-1:SUBB_W];
      sub_d  = word[SUBB_W-1:0];
      ferr_d = |word[FRAME_LEN-1:FRAME_LEN-LEAD_LEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sub_q  <= '0;
      ferr_q <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      sub_q  <= sub_d;
      ferr_q <= ferr_d;
      val_q  <= done;
    end
  end

  assign code      = code_q;
  assign sub_bits  = sub_q;
  assign frame_err = ferr_q;
  assign valid     = val_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid) else $error("valid longer than one cycle"); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(code) && $stable(sub_bits) && $stable(frame_err)))
    else $error("result moved without valid"); // R4
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n)) else $error("valid not at cs rise"); // R4
  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy) else $error("selected while not busy"); // R8
endmodule

// File: tb/adc_rd_ctrl_tb.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb;
  import adc_rd_pkg::*;
  localparam int DIV_W = 8, CH_W = 2, SETUP_CYC = 10, CSH_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0, cont_en = 1'b0, miso = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd12;
  logic [CH_W-1:0]  chan_last = 2'd2;
  logic cs_n, sclk, busy, valid, frame_err;
  logic [CODE_W-1:0] code;
  logic [SUBB_W-1:0] sub_bits;
  logic [CH_W-1:0]   mux_sel;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.DIV_W(DIV_W), .CH_W(CH_W), .SETUP_CYC(SETUP_CYC), .CSH_CYC(CSH_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cont_en(cont_en),
    .half_div(half_div), .chan_last(chan_last), .cs_n(cs_n), .sclk(sclk), .miso(miso),
    .busy(busy), .valid(valid), .code(code), .sub_bits(sub_bits),
    .frame_err(frame_err), .mux_sel(mux_sel)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural converter
  logic [23:0] dev_word = 24'h0;
  int dev_dly = 20, dev_idx = 0;
  always @(negedge cs_n) begin
    dev_idx = 0;
    #(dev_dly);
    miso = dev_word[23];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      dev_idx = dev_idx + 1;
      #(dev_dly);
      miso = (dev_idx < 24) ? dev_word[23-dev_idx] : 1'b0;
    end
  end

  function automatic logic [23:0] mk(input logic [7:0] lead, input logic [13:0] c, input logic [1:0] s);
    return {lead, c, s};
  endfunction
  function automatic logic [16:0] exp_of(input logic [23:0] w);
    return {|w[23:16], w[15:2], w[1:0]};
  endfunction

  // scoreboard and pin monitor
  logic [16:0] exp_q[$];
  int nvalid = 0, nframes = 0, rises = 0, falls = 0, lo_pre = 0, hi_run = 0, hperr = 0;
  int hi_cnt = 0, idle_bad = 0, cyc = 0;
  bit have_gap = 0, cont_run = 0, prev_cs = 1, prev_s = 0, done_flag = 0;
  logic [CH_W-1:0] prev_mux = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        nframes++; rises = 0; falls = 0; lo_pre = 0; hperr = 0;
        if (have_gap) begin
          if (cont_run && cont_en) chk(hi_cnt == CSH_CYC, "R9 cs high gap", hi_cnt, CSH_CYC);
          else chk(hi_cnt >= CSH_CYC, "R7 cs high gap", hi_cnt, CSH_CYC);
        end
      end
      if (!prev_cs && cs_n) begin hi_cnt = 0; have_gap = 1; end
      if (cs_n) hi_cnt++;
      if (cs_n && sclk) idle_bad++;
      if (!prev_s && sclk) begin
        rises++; hi_run = 0;
        if (rises == 1) chk(lo_pre == SETUP_CYC + int'(half_div), "R6 setup", lo_pre, SETUP_CYC + int'(half_div));
      end
      if (sclk) hi_run++;
      if (prev_s && !sclk) begin
        falls++;
        if (hi_run != int'(half_div)) hperr++;
      end
      if (!cs_n && !sclk && rises == 0) lo_pre++;
      if (mux_sel != prev_mux) begin
        chk(falls == ACQ_FALLS, "R11 mux edge", falls, ACQ_FALLS);
        chk(mux_sel == ((prev_mux >= chan_last) ? '0 : prev_mux + 1'b1), "R11 mux value",
            mux_sel, (prev_mux >= chan_last) ? 0 : prev_mux + 1);
      end
      if (valid) begin
        nvalid++;
        chk(rises == 24, "R3 rising edges", rises, 24);
        chk(falls == 24, "R3 falling edges", falls, 24);
        chk(cs_n == 1'b1, "R4 valid with cs rise", cs_n, 1);
        chk(hperr == 0, "R2 high phase", hperr, 0);
        if (exp_q.size() == 0) chk(0, "R8 unexpected result", 1, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk(code == e[15:2], "R4 code", code, e[15:2]);
          chk(sub_bits == e[1:0], "R4 sub bits", sub_bits, e[1:0]);
          chk(frame_err == e[16], "R5 frame error", frame_err, e[16]);
        end
        if (cont_en) cont_run = 1;
      end
      if (!cont_en) cont_run = 0;
      prev_cs = cs_n; prev_s = sclk; prev_mux = mux_sel;
    end
  end

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      report();
    end
  end

  task automatic wait_valid(input int target);
    do @(posedge clk); while (nvalid < target);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    repeat (CSH_CYC + 2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_frame(input logic [23:0] w);
    int target;
    dev_word = w;
    exp_q.push_back(exp_of(w));
    target = nvalid + 1;
    pulse_start();
    wait_valid(target);
  endtask

  task automatic abort_at(input int nr, input logic [23:0] w);
    int v0;
    logic [13:0] c0;
    logic [CH_W-1:0] m0;
    v0 = nvalid; c0 = code; m0 = mux_sel;
    dev_word = w;
    pulse_start();
    do @(posedge clk); while (rises < nr);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(cs_n == 1'b1, "R10 cs after abort", cs_n, 1);
    chk(sclk == 1'b0, "R10 sclk after abort", sclk, 0);
    repeat (60) @(negedge clk);
    chk(nvalid == v0, "R10 no valid", nvalid, v0);
    chk(code == c0, "R10 code kept", code, c0);
    chk(busy == 1'b0, "R10 idle", busy, 0);
    if (nr < ACQ_FALLS) chk(mux_sel == m0, "R11 mux kept on early abort", mux_sel, m0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(busy == 1'b0 && valid == 1'b0, "R1 busy/valid", {busy, valid}, 0);
    chk(code == '0 && frame_err == 1'b0 && mux_sel == '0, "R1 outputs", code, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 stays idle", cs_n, 1);

    do_frame(mk(8'h00, 14'h3FFF, 2'b11));
    do_frame(mk(8'h00, 14'h0000, 2'b00));
    do_frame(mk(8'h00, 14'h2AAA, 2'b01));
    do_frame(mk(8'h00, 14'h1555, 2'b10));

    half_div = 8'd15; dev_dly = 100;
    do_frame(mk(8'h00, 14'h2001, 2'b00));
    do_frame(mk(8'h80, 14'h0F0F, 2'b10));
    do_frame(mk(8'h01, 14'h00F0, 2'b01));
    do_frame(mk(8'h00, 14'h1234, 2'b11));
    half_div = 8'd12; dev_dly = 20;

    begin : busy_start
      int f0, v0;
      f0 = nframes; v0 = nvalid;
      dev_word = mk(8'h00, 14'h0ABC, 2'b01);
      exp_q.push_back(exp_of(dev_word));
      pulse_start();
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      wait_valid(v0 + 1);
      repeat (40) @(negedge clk);
      chk(nframes == f0 + 1, "R8 frames", nframes, f0 + 1);
      chk(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);
    end

    abort_at(10, mk(8'h00, 14'h0777, 2'b10));
    abort_at(3, mk(8'h00, 14'h3777, 2'b01));
    do_frame(mk(8'h00, 14'h2468, 2'b10));

    begin : cont_mode
      int v0;
      v0 = nvalid;
      dev_word = mk(8'h00, 14'h1357, 2'b11);
      repeat (3) exp_q.push_back(exp_of(dev_word));
      @(negedge clk) cont_en = 1'b1;
      wait_valid(v0 + 3);
      cont_en = 1'b0;
      repeat (80) @(negedge clk);
      chk(nvalid == v0 + 3, "R9 frame count", nvalid, v0 + 3);
      chk(exp_q.size() == 0, "R9 queue empty", exp_q.size(), 0);
    end

    chk(idle_bad == 0, "R2 sclk idle low", idle_bad, 0);
    report();
  end
endmodule